// File: doc/BRIEF.md
# Fundamental-Mode Feedback Circuit Emulator

This block is a clock-stepped model of a tiny asynchronous sequential circuit. It has one external input x and two secondary state variables y1 and y2. The combinational next-state network computes the excitation pair Y1Y2 from the total state, which is the present pair y1y2 together with the held input x. On each clock edge where Y differs from y, the block performs exactly one feedback step and copies Y into y. It repeats this until the excitation matches the present state.

A caller presents a new input value on `x_in` and pulses `apply`. The block accepts the value only while the total state is stable. This enforces the fundamental-mode rule that inputs change only once the circuit has settled. A strobe that arrives during settling is dropped and recorded in a sticky protocol error. A bounded settling counter watches for a loop that never converges and flags it as an oscillation.

Top module: `fm_async_emu`

## Requirements
- R1: While the total state is unstable, each rising clock edge loads y1 with x·y1 + x'·y2 and y2 with x·y1' + x'·y2, computed from the values before the edge. This is exactly one step per cycle.
- R2: `stable` is high in the same cycle, combinationally, exactly when the excitation pair equals y1y2 for the held x.
- R3: An `apply` pulse sampled while `stable` is high loads `x_in` as the held input at that edge. Applying the value already held leaves y1y2 and `stable` unchanged.
- R4: An `apply` pulse sampled while `stable` is low does not change the held input. It sets `proto_err`, which stays high until reset.
- R5: Synchronous active-high reset gives y1y2 = 00, held x = 0, `stable` = 1, `proto_err` = 0 and `osc_err` = 0.
- R6: While `stable` is high, y1 and y2 do not change at the next edge.
- R7: Each accepted input change settles after at most one update. Starting from 00 with x=0, alternating inputs visit the stable states 01 (x=1), 11 (x=0), 10 (x=1) and 00 (x=0) in turn.
- R8: `osc_err` rises only when the state is still unstable after MAX_ITER consecutive updates, and it stays high until reset. With these excitation functions it never rises under legal or illegal strobing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| x_in | input | 1 | Candidate input value |
| apply | input | 1 | Strobe that applies `x_in` |
| y1 | output | 1 | Secondary state variable 1 |
| y2 | output | 1 | Secondary state variable 2 |
| stable | output | 1 | Total state is stable |
| proto_err | output | 1 | Sticky: strobe arrived while unstable |
| osc_err | output | 1 | Sticky: settling limit exceeded |

## Verification
The bench walks every stable total state with both input values, including re-applying the held value. A design with a wrong excitation term would land on a different stable pair, or would report instability where none exists. It also strobes the opposite value during the single settling cycle. A design that latched that strobe would leave a total state that is stable at the wrong input, or one that does not settle, and a design that forgot the sticky flag would show `proto_err` low. Reset is checked after errors have been raised, to catch a flag that survives reset or a non-zero start state.

// File: rtl/fm_async_emu.sv
module fm_async_emu #(
  parameter int MAX_ITER = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic x_in,
  input  logic apply,
  output logic y1,
  output logic y2,
  output logic stable,
  output logic proto_err,
  output logic osc_err
);
  localparam int CW = $clog2(MAX_ITER + 2);

  logic          x_q;
  logic [1:0]    y_q;
  logic [1:0]    y_nx;
  logic [CW-1:0] iter_cnt;

  assign y_nx[1] = (x_q & y_q[1]) | (~x_q & y_q[0]);
  assign y_nx[0] = (x_q & ~y_q[1]) | (~x_q & y_q[0]);
  assign stable  = (y_nx == y_q);
  assign y1      = y_q[1];
  assign y2      = y_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q       <= 1'b0;
      y_q       <= 2'b00;
      iter_cnt  <= '0;
      proto_err <= 1'b0;
      osc_err   <= 1'b0;
    end else if (stable) begin
      iter_cnt <= '0;
      if (apply) x_q <= x_in;
    end else begin
      y_q <= y_nx;
      if (apply) proto_err <= 1'b1;
      if (iter_cnt >= CW'(MAX_ITER)) osc_err <= 1'b1;
      else iter_cnt <= iter_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/fm_async_emu_chk.sv
module fm_async_emu_chk (
  input logic clk,
  input logic rst,
  input logic apply,
  input logic x_q,
  input logic y1,
  input logic y2,
  input logic stable,
  input logic proto_err,
  input logic osc_err
);
  p_step_r1: assert property (@(posedge clk) disable iff (rst)
    !stable |=> (y1 == (($past(x_q) & $past(y1)) | (!$past(x_q) & $past(y2))) &&
                 y2 == (($past(x_q) & !$past(y1)) | (!$past(x_q) & $past(y2)))));
  p_hold_x_r4: assert property (@(posedge clk) disable iff (rst)
    !stable |=> $stable(x_q));
  p_set_proto_r4: assert property (@(posedge clk) disable iff (rst)
    (apply && !stable) |=> proto_err);
  p_sticky_proto_r4: assert property (@(posedge clk) disable iff (rst)
    proto_err |=> proto_err);
  p_hold_y_r6: assert property (@(posedge clk) disable iff (rst)
    stable |=> ($stable(y1) && $stable(y2)));
  p_one_step_r7: assert property (@(posedge clk) disable iff (rst)
    !stable |=> stable);
  p_no_osc_r8: assert property (@(posedge clk) disable iff (rst)
    !osc_err);
endmodule

bind fm_async_emu fm_async_emu_chk chk_i (
  .clk(clk), .rst(rst), .apply(apply), .x_q(x_q), .y1(y1), .y2(y2),
  .stable(stable), .proto_err(proto_err), .osc_err(osc_err)
);

// File: tb/fm_async_emu_tb_top.sv
module fm_async_emu_tb_top;
  logic clk = 1'b0;
  logic rst, x_in, apply;
  logic y1, y2, stable, proto_err, osc_err;
  int checks = 0;
  int failures = 0;
  logic mx;
  logic [1:0] my;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fm_async_emu dut_i (
    .clk(clk), .rst(rst), .x_in(x_in), .apply(apply), .y1(y1), .y2(y2),
    .stable(stable), .proto_err(proto_err), .osc_err(osc_err)
  );

  function automatic logic [1:0] excite(logic x, logic [1:0] y);
    return {(x & y[1]) | (~x & y[0]), (x & ~y[1]) | (~x & y[0])};
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; apply = 1'b0; x_in = 1'b0;
    @(posedge clk); #1; rst = 1'b0;
    mx = 1'b0; my = 2'b00;
    check("R5 reset state", {3'b0, y1, y2, stable, proto_err, osc_err},
          {3'b0, 2'b00, 3'b100});
  endtask

  task automatic apply_x(logic v);
    logic [1:0] nx;
    @(negedge clk); x_in = v; apply = 1'b1;
    @(posedge clk); #1; apply = 1'b0;
    mx = v;
    nx = excite(mx, my);
    check("R2 stable after apply", {7'b0, stable}, {7'b0, nx == my});
    check("R3/R6 y held at apply edge", {6'b0, y1, y2}, {6'b0, my});
    if (nx != my) begin
      @(posedge clk); #1;
      my = nx;
      check("R1/R7 one update", {6'b0, y1, y2}, {6'b0, my});
      check("R7 settled", {7'b0, stable}, {7'b0, 1'b1});
    end
    check("R8 no osc", {7'b0, osc_err}, 8'h0);
  endtask

  initial begin
    rst = 1'b1; apply = 1'b0; x_in = 1'b0;
    do_reset();
    check("R4 no proto after reset", {7'b0, proto_err}, 8'h0);
    apply_x(1'b1); check("R7 state 01", {6'b0, y1, y2}, 8'h1);
    apply_x(1'b0); check("R7 state 11", {6'b0, y1, y2}, 8'h3);
    apply_x(1'b1); check("R7 state 10", {6'b0, y1, y2}, 8'h2);
    apply_x(1'b0); check("R7 state 00", {6'b0, y1, y2}, 8'h0);
    for (int i = 0; i < 64; i++) apply_x(1'((i * 7 + (i >> 2)) % 3 == 0));
    for (int i = 0; i < 8; i++) apply_x(mx);
    check("R4 legal strobes leave proto low", {7'b0, proto_err}, 8'h0);

    do_reset();
    @(negedge clk); x_in = 1'b1; apply = 1'b1;
    @(posedge clk); #1; x_in = 1'b0;
    check("R2 unstable after change", {7'b0, stable}, 8'h0);
    @(posedge clk); #1; apply = 1'b0;
    check("R4 proto set", {7'b0, proto_err}, 8'h1);
    check("R4 held x kept, y=01", {6'b0, y1, y2}, 8'h1);
    repeat (3) begin
      @(posedge clk); #1;
      check("R4 x not reloaded, stable", {7'b0, stable}, 8'h1);
      check("R4 proto sticky", {7'b0, proto_err}, 8'h1);
      check("R6 y held", {6'b0, y1, y2}, 8'h1);
    end
    check("R8 no osc after illegal strobe", {7'b0, osc_err}, 8'h0);
    do_reset();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule